// File: doc/BRIEF.md
# Display DMA Frame Descriptor Fetch Engine

This block loads the per-frame descriptors of a multi-channel display DMA. When a frame boundary is signalled it walks the channels from the lowest index upward. For each channel that the display configuration has turned on, it picks the descriptor address: a pending software branch takes priority over the linked chain pointer. It then reads the four descriptor words through a single-outstanding read port with a valid/ready request handshake, and keeps the next-descriptor pointer, the frame source address, the frame identifier and the command word.

Software programs each channel's chain pointer and branch register through a simple write port, and reads back all of the per-channel state through a read mux. The engine pulses a branch event when a branch that asks for an interrupt is taken. It pulses a bus error when a channel ends its load without a usable source address. A single-cycle done pulse closes each pass. Pixel fetching and palette handling belong to neighbouring blocks.

Top module: `frame_desc_fetch`

## Requirements
- R1: After reset every per-channel register (pointer, branch, source, identifier, command) reads zero, `done` is low and no memory request is made.
- R2: Register write select code 0 writes a channel's descriptor pointer with bits 3:0 forced to zero. Code 1 writes its branch register keeping only the bits of mask 0xFFFFFFF3. Read select codes are 0 pointer, 1 branch, 2 source, 3 identifier and 4 command.
- R3: Channel enables are derived as follows: channel 0 from `ctrlEnable`; channel 1 from `ovl1Enable` or `dualScan`; channels 2, 3 and 4 from `ovl2Enable`; channel 5 from `cursorEnable`. Channel 6 and above are never enabled, and their branch request bit stays set.
- R4: When an enabled channel's branch register has bit 0 (request) set, the descriptor address is the branch value with bits 3:0 zeroed, and bit 0 is cleared while bit 1 is kept. If bit 1 (interrupt enable) is also set, `branchEvtValid` pulses for one cycle with that channel on `branchEvtCh`. This happens even when the branch address is outside the window.
- R5: Without a branch request the descriptor address is the channel pointer. After a successful fetch, word 0 replaces the pointer, word 1 becomes the source, word 2 the identifier and word 3 the command, all stored unmodified.
- R6: A descriptor fetch issues four reads at the descriptor address plus 0, 4, 8 and 12, in that order. Only one read is outstanding at a time, and each request holds its address until accepted.
- R7: A descriptor address below `WIN_BASE`, or whose 16-byte descriptor would end beyond `WIN_BASE + WIN_SIZE`, is not read. That channel's pointer, identifier and command are left unchanged.
- R8: At the start of each pass the source of every channel is cleared to zero, so disabled or skipped channels read a zero source afterwards.
- R9: After its load, an enabled channel whose source is zero, below `WIN_BASE` or above `WIN_BASE + WIN_SIZE` pulses `busErrValid` for one cycle with the channel on `busErrCh`.
- R10: Channels are processed in ascending order, so bus error events come out in increasing channel order. `done` pulses for exactly one cycle per pass after the last channel. A `frameStart` that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame boundary pulse that starts a pass |
| ctrlEnable | input | 1 | Base plane enable (channel 0) |
| dualScan | input | 1 | Dual-scan mode (enables channel 1) |
| ovl1Enable | input | 1 | First overlay enable (channel 1) |
| ovl2Enable | input | 1 | Second overlay enable (channels 2 to 4) |
| cursorEnable | input | 1 | Cursor enable (channel 5) |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Write target: 0 pointer, 1 branch |
| regWrCh | input | CH_W | Channel written |
| regWrData | input | 32 | Write data |
| regRdSel | input | 3 | Read select: 0 pointer, 1 branch, 2 source, 3 identifier, 4 command |
| regRdCh | input | CH_W | Channel read |
| regRdData | output | 32 | Read data (combinational) |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 32 | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| branchEvtValid | output | 1 | Branch interrupt event pulse |
| branchEvtCh | output | CH_W | Channel of the branch event |
| busErrValid | output | 1 | Bus error event pulse |
| busErrCh | output | CH_W | Channel of the bus error |
| done | output | 1 | Pass complete pulse |

## Verification
A branch event is registered and appears one cycle after the scan cycle that selects the channel. A bus error appears one cycle after the channel's check cycle. `done` is a state output visible in the cycle after the last channel finishes, while readback data is combinational from the registers. The bench therefore collects the single-cycle events on every falling edge into per-channel tallies and an ordered list, and checks each request address as the handshake completes. It compares registers and tallies against its own model of the pass only once `done` has been seen and the engine is idle, with readback sampled at a falling edge after the select has settled.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] BRANCH_KEEP = 32'hFFFF_FFF3;
  localparam logic [WORD_W-1:0] PTR_KEEP    = 32'hFFFF_FFF0;

  localparam logic [2:0] SEL_PTR    = 3'd0;
  localparam logic [2:0] SEL_BRANCH = 3'd1;
  localparam logic [2:0] SEL_SRC    = 3'd2;
  localparam logic [2:0] SEL_ID     = 3'd3;
  localparam logic [2:0] SEL_CMD    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_REQ, ST_WAIT, ST_CHECK, ST_FIN
  } fetchState_e;

  typedef struct packed {
    logic clrSrc;    // start of pass: wipe all sources
    logic pickDesc;  // choose descriptor address for current channel
    logic capture;   // a descriptor word has arrived
    logic checkSrc;  // evaluate current channel's source
  } dpCtl_t;
endpackage

// File: rtl/fdf_control.sv
module fdf_control
  import fdf_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameStart,
  input  logic [NUM_CH-1:0]         chEn,
  input  logic                      descOk,
  input  logic                      memReqReady,
  input  logic                      memRspValid,
  output dpCtl_t                    ctl,
  output logic [$clog2(NUM_CH)-1:0] chIdx,
  output logic [1:0]                wordIdx,
  output logic                      memReqValid,
  output logic                      done
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  fetchState_e state;
  logic isLast;
  assign isLast = (chIdx == LAST_CH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      chIdx   <= '0;
      wordIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (frameStart) begin
          state <= ST_SCAN;
          chIdx <= '0;
        end
        ST_SCAN: begin
          if (chEn[chIdx]) begin
            wordIdx <= '0;
            state   <= descOk ? ST_REQ : ST_CHECK;
          end else if (isLast) begin
            state <= ST_FIN;
          end else begin
            chIdx <= chIdx + 1'b1;
          end
        end
        ST_REQ: if (memReqReady) state <= ST_WAIT;
        ST_WAIT: if (memRspValid) begin
          if (wordIdx == 2'd3) state <= ST_CHECK;
          else begin
            wordIdx <= wordIdx + 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_CHECK: begin
          if (isLast) state <= ST_FIN;
          else begin
            chIdx <= chIdx + 1'b1;
            state <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clrSrc   = (state == ST_IDLE) && frameStart;
    ctl.pickDesc = (state == ST_SCAN) && chEn[chIdx];
    ctl.capture  = (state == ST_WAIT) && memRspValid;
    ctl.checkSrc = (state == ST_CHECK);
  end

  assign memReqValid = (state == ST_REQ);
  assign done        = (state == ST_FIN);

  // R10: a pass ends with a single-cycle done
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: within a pass the channel index never moves backward
  assert_ascending_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> chIdx >= $past(chIdx));
endmodule

// File: rtl/fdf_datapath.sv
module fdf_datapath
  import fdf_pkg::*;
#(
  parameter int          NUM_CH   = 7,
  parameter logic [31:0] WIN_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_1000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [$clog2(NUM_CH)-1:0] chIdx,
  input  logic [1:0]                wordIdx,
  input  logic                      ctrlEnable,
  input  logic                      dualScan,
  input  logic                      ovl1Enable,
  input  logic                      ovl2Enable,
  input  logic                      cursorEnable,
  input  logic                      regWrEn,
  input  logic [2:0]                regWrSel,
  input  logic [$clog2(NUM_CH)-1:0] regWrCh,
  input  logic [WORD_W-1:0]         regWrData,
  input  logic [2:0]                regRdSel,
  input  logic [$clog2(NUM_CH)-1:0] regRdCh,
  output logic [WORD_W-1:0]         regRdData,
  input  logic [WORD_W-1:0]         memRspData,
  output logic [WORD_W-1:0]         memReqAddr,
  output logic [NUM_CH-1:0]         chEn,
  output logic                      descOk,
  output logic                      branchEvtValid,
  output logic [$clog2(NUM_CH)-1:0] branchEvtCh,
  output logic                      busErrValid,
  output logic [$clog2(NUM_CH)-1:0] busErrCh
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [WORD_W:0] BASE_X = {1'b0, WIN_BASE};
  localparam logic [WORD_W:0] END_X  = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic [WORD_W-1:0] ptrReg [NUM_CH];
  logic [WORD_W-1:0] brReg  [NUM_CH];
  logic [WORD_W-1:0] srcReg [NUM_CH];
  logic [WORD_W-1:0] idReg  [NUM_CH];
  logic [WORD_W-1:0] cmdReg [NUM_CH];
  logic [WORD_W-1:0] curAddr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hitCh, swHit;
    assign hitCh = (chIdx == CH_W'(c));
    assign swHit = regWrEn && (regWrCh == CH_W'(c));

    if (c == 0)           begin : g_en0 assign chEn[c] = ctrlEnable; end
    else if (c == 1)      begin : g_en1 assign chEn[c] = ovl1Enable | dualScan; end
    else if (c <= 4)      begin : g_en2 assign chEn[c] = ovl2Enable; end
    else if (c == 5)      begin : g_en5 assign chEn[c] = cursorEnable; end
    else                  begin : g_enx assign chEn[c] = 1'b0; end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrReg[c] <= '0;
        brReg[c]  <= '0;
        srcReg[c] <= '0;
        idReg[c]  <= '0;
        cmdReg[c] <= '0;
      end else begin
        if (swHit && regWrSel == SEL_PTR)    ptrReg[c] <= regWrData & PTR_KEEP;
        if (swHit && regWrSel == SEL_BRANCH) brReg[c]  <= regWrData & BRANCH_KEEP;
        if (ctl.pickDesc && hitCh && brReg[c][0]) brReg[c][0] <= 1'b0;
        if (ctl.clrSrc) srcReg[c] <= '0;
        if (ctl.capture && hitCh) begin
          case (wordIdx)
            2'd0: ptrReg[c] <= memRspData;
            2'd1: srcReg[c] <= memRspData;
            2'd2: idReg[c]  <= memRspData;
            default: cmdReg[c] <= memRspData;
          endcase
        end
      end
    end
  end

  logic [WORD_W-1:0] curBr, selAddr, curSrc;
  logic srcBad;
  assign curBr   = brReg[chIdx];
  assign selAddr = curBr[0] ? (curBr & PTR_KEEP) : ptrReg[chIdx];
  assign descOk  = ({1'b0, selAddr} >= BASE_X) &&
                   ({1'b0, selAddr} + 33'd16 <= END_X);
  assign curSrc  = srcReg[chIdx];
  assign srcBad  = (curSrc == '0) || ({1'b0, curSrc} < BASE_X) ||
                   ({1'b0, curSrc} > END_X);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr        <= '0;
      branchEvtValid <= 1'b0;
      branchEvtCh    <= '0;
      busErrValid    <= 1'b0;
      busErrCh       <= '0;
    end else begin
      if (ctl.pickDesc) curAddr <= selAddr;
      branchEvtValid <= ctl.pickDesc && curBr[0] && curBr[1];
      branchEvtCh    <= chIdx;
      busErrValid    <= ctl.checkSrc && srcBad;
      busErrCh       <= chIdx;
    end
  end

  assign memReqAddr = curAddr + {{(WORD_W-4){1'b0}}, wordIdx, 2'b00};

  always_comb begin
    regRdData = '0;
    if (int'(regRdCh) < NUM_CH) begin
      case (regRdSel)
        SEL_PTR:    regRdData = ptrReg[regRdCh];
        SEL_BRANCH: regRdData = brReg[regRdCh];
        SEL_SRC:    regRdData = srcReg[regRdCh];
        SEL_ID:     regRdData = idReg[regRdCh];
        SEL_CMD:    regRdData = cmdReg[regRdCh];
        default:    regRdData = '0;
      endcase
    end
  end

  // R4/R9: the two event kinds come from different phases of a channel
  assert_evt_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    branchEvtValid |-> !busErrValid);

  // R8: right after the pass opens, the channel under scan has no source
  assert_src_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrSrc |=> (curSrc == '0));
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch
  import fdf_pkg::*;
#(
  parameter int          NUM_CH   = 7,
  parameter logic [31:0] WIN_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_1000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameStart,
  input  logic                      ctrlEnable,
  input  logic                      dualScan,
  input  logic                      ovl1Enable,
  input  logic                      ovl2Enable,
  input  logic                      cursorEnable,
  input  logic                      regWrEn,
  input  logic [2:0]                regWrSel,
  input  logic [$clog2(NUM_CH)-1:0] regWrCh,
  input  logic [31:0]               regWrData,
  input  logic [2:0]                regRdSel,
  input  logic [$clog2(NUM_CH)-1:0] regRdCh,
  output logic [31:0]               regRdData,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [31:0]               memReqAddr,
  input  logic                      memRspValid,
  input  logic [31:0]               memRspData,
  output logic                      branchEvtValid,
  output logic [$clog2(NUM_CH)-1:0] branchEvtCh,
  output logic                      busErrValid,
  output logic [$clog2(NUM_CH)-1:0] busErrCh,
  output logic                      done
);
  localparam int CH_W = $clog2(NUM_CH);

  dpCtl_t            ctl;
  logic [CH_W-1:0]   chIdx;
  logic [1:0]        wordIdx;
  logic [NUM_CH-1:0] chEn;
  logic              descOk;

  fdf_control #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .chEn(chEn),
    .descOk(descOk), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .ctl(ctl), .chIdx(chIdx), .wordIdx(wordIdx),
    .memReqValid(memReqValid), .done(done)
  );

  fdf_datapath #(.NUM_CH(NUM_CH), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chIdx(chIdx), .wordIdx(wordIdx),
    .ctrlEnable(ctrlEnable), .dualScan(dualScan), .ovl1Enable(ovl1Enable),
    .ovl2Enable(ovl2Enable), .cursorEnable(cursorEnable),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrCh(regWrCh),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdCh(regRdCh),
    .regRdData(regRdData), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .chEn(chEn), .descOk(descOk),
    .branchEvtValid(branchEvtValid), .branchEvtCh(branchEvtCh),
    .busErrValid(busErrValid), .busErrCh(busErrCh)
  );

  // R6: a request that waits keeps its address
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R6: descriptor words are read at word-aligned addresses
  assert_req_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00));
endmodule

// File: tb/sim_frame_desc_fetch.sv
module sim_frame_desc_fetch;
  localparam int NC = 7;
  localparam logic [31:0] BASE = 32'hA000_0000;
  localparam logic [31:0] SIZE = 32'h0000_1000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, frameStart = 1'b0;
  logic ctrlEnable = 0, dualScan = 0, ovl1Enable = 0, ovl2Enable = 0, cursorEnable = 0;
  logic regWrEn = 0;
  logic [2:0] regWrSel = 0, regRdSel = 0;
  logic [2:0] regWrCh = 0, regRdCh = 0;
  logic [31:0] regWrData = 0, regRdData, memReqAddr, memRspData;
  logic memReqValid, memReqReady, memRspValid;
  logic branchEvtValid, busErrValid, done;
  logic [2:0] branchEvtCh, busErrCh;

  frame_desc_fetch #(.NUM_CH(NC), .WIN_BASE(BASE), .WIN_SIZE(SIZE)) u0 (.*);

  int nCmp = 0, nBad = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------- memory model ----------
  function automatic logic [31:0] memWord(input logic [31:0] a);
    int d = int'((a - BASE) >> 4);
    case (a[3:2])
      2'd0: return (d % 7 == 6) ? 32'h2000_0000 : BASE + 32'(((d * 3 + 1) % 256) << 4);
      2'd1: return (d % 5 == 3) ? 32'h0 : (d % 5 == 4) ? BASE + SIZE + 32'd4 : BASE + 32'(d * 8);
      2'd2: return 32'h1D00_0000 | 32'(d);
      default: return 32'(d << 2) | (32'(d & 1) << 21) | (32'((d >> 1) & 1) << 22) |
                      (32'((d >> 2) & 1) << 26);
    endcase
  endfunction
  function automatic bit inWin(input logic [31:0] a);
    return ({1'b0, a} >= {1'b0, BASE}) && ({1'b0, a} + 33'd16 <= {1'b0, BASE} + {1'b0, SIZE});
  endfunction
  function automatic bit srcBad(input logic [31:0] s);
    return (s == 0) || (s < BASE) || ({1'b0, s} > {1'b0, BASE} + {1'b0, SIZE});
  endfunction

  logic [3:0] rdyCnt = 0;
  logic pend = 0;
  logic [1:0] lat = 0;
  logic [31:0] rspAddr = 0;
  assign memReqReady = rdyCnt[0] | rdyCnt[2];
  assign memRspValid = pend && (lat == 0);
  assign memRspData  = memRspValid ? memWord(rspAddr) : 32'hDEAD_BEEF;

  logic [31:0] expReq [0:63];
  int expReqN = 0, gotReqN = 0, reqBad = 0;

  always @(posedge clk) begin
    rdyCnt <= rdyCnt + 1'b1;
    if (pend && lat != 0) lat <= lat - 1'b1;
    if (memRspValid) pend <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      if (pend) reqBad++;                                   // R6 single outstanding
      if (gotReqN >= expReqN || memReqAddr !== expReq[gotReqN]) reqBad++;
      gotReqN++;
      pend    <= 1'b1;
      lat     <= memReqAddr[3:2];
      rspAddr <= memReqAddr;
    end
  end

  // ---------- event monitor ----------
  int gotBr [NC];
  int gotErr [0:15];
  int gotErrN = 0, doneCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (branchEvtValid) gotBr[branchEvtCh]++;
      if (busErrValid) begin
        if (gotErrN < 16) gotErr[gotErrN] = int'(busErrCh);
        gotErrN++;
      end
      if (done) doneCnt++;
    end
  end

  // ---------- reference model ----------
  logic [31:0] mPtr [NC], mBr [NC], mSrc [NC], mId [NC], mCmd [NC];
  int expBr [NC];
  int expErr [0:15];
  int expErrN = 0;

  function automatic bit chOn(input int c, input logic [4:0] p);
    // p = {cursor, ovl2, ovl1, dual, ctrl}
    case (c)
      0: return p[0];
      1: return p[1] | p[2];
      2, 3, 4: return p[3];
      5: return p[4];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model(input logic [4:0] p);
    logic [31:0] a;
    expReqN = 0; expErrN = 0;
    for (int c = 0; c < NC; c++) begin expBr[c] = 0; mSrc[c] = 0; end
    for (int c = 0; c < NC; c++) begin
      if (chOn(c, p)) begin
        if (mBr[c][0]) begin
          a = mBr[c] & 32'hFFFF_FFF0;
          if (mBr[c][1]) expBr[c]++;
          mBr[c][0] = 1'b0;
        end else a = mPtr[c];
        if (inWin(a)) begin
          for (int w = 0; w < 4; w++) begin expReq[expReqN] = a + 32'(4 * w); expReqN++; end
          mPtr[c] = memWord(a);
          mSrc[c] = memWord(a + 4);
          mId[c]  = memWord(a + 8);
          mCmd[c] = memWord(a + 12);
        end
        if (srcBad(mSrc[c])) begin expErr[expErrN] = c; expErrN++; end
      end
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int ch, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regWrSel = sel; regWrCh = 3'(ch); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    if (sel == 0) mPtr[ch] = d & 32'hFFFF_FFF0;
    else          mBr[ch]  = d & 32'hFFFF_FFF3;
  endtask

  task automatic rd(input logic [2:0] sel, input int ch, output logic [31:0] v);
    @(negedge clk);
    regRdSel = sel; regRdCh = 3'(ch);
    #1 v = regRdData;
  endtask

  task automatic compareAll(input logic [4:0] p);
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      rd(3'd0, c, v); chk($sformatf("R5 ptr ch%0d", c), v, mPtr[c]);
      rd(3'd1, c, v); chk($sformatf("%s branch ch%0d", c == 6 ? "R3" : "R4", c), v, mBr[c]);
      rd(3'd2, c, v); chk($sformatf("%s source ch%0d", chOn(c, p) ? "R5" : "R8", c), v, mSrc[c]);
      rd(3'd3, c, v); chk($sformatf("R5 id ch%0d", c), v, mId[c]);
      rd(3'd4, c, v); chk($sformatf("R5 cmd ch%0d", c), v, mCmd[c]);
      chk($sformatf("R4 branch events ch%0d", c), 32'(gotBr[c]), 32'(expBr[c]));
    end
  endtask

  task automatic doFrame(input logic [4:0] p, input bit extraStart);
    int t;
    model(p);
    for (int c = 0; c < NC; c++) gotBr[c] = 0;
    gotErrN = 0; doneCnt = 0; gotReqN = 0; reqBad = 0;
    @(negedge clk);
    {cursorEnable, ovl2Enable, ovl1Enable, dualScan, ctrlEnable} = p;
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
    if (extraStart) begin
      repeat (2) @(negedge clk);
      frameStart = 1;
      @(negedge clk);
      frameStart = 0;
    end
    t = 0;
    while (doneCnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk("R10 done pulses per pass", 32'(doneCnt), 32'd1);
    chk("R6 request count", 32'(gotReqN), 32'(expReqN));
    chk("R6/R7 request order and overlap", 32'(reqBad), 32'd0);
    chk("R9 bus error count", 32'(gotErrN), 32'(expErrN));
    for (int i = 0; i < expErrN && i < gotErrN && i < 16; i++)
      chk("R10 bus error channel order", 32'(gotErr[i]), 32'(expErr[i]));
    compareAll(p);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      mPtr[c] = 0; mBr[c] = 0; mSrc[c] = 0; mId[c] = 0; mCmd[c] = 0; gotBr[c] = 0; expBr[c] = 0;
    end
    repeat (5) @(negedge clk);
    chk("R1 no request in reset", {31'b0, memReqValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1 done low", {31'b0, done}, 32'd0);
    chk("R1 no request", {31'b0, memReqValid}, 32'd0);
    compareAll(5'b0);

    // R2 masking
    wr(3'd0, 2, 32'hA000_0017); rd(3'd0, 2, v); chk("R2 pointer low bits", v, 32'hA000_0010);
    wr(3'd1, 4, 32'hFFFF_FFFF); rd(3'd1, 4, v); chk("R2 branch mask", v, 32'hFFFF_FFF3);
    wr(3'd1, 4, 32'h0);

    for (int c = 0; c < NC; c++) wr(3'd0, c, BASE + 32'(c * 64));
    wr(3'd1, 6, BASE | 32'h3);                       // R3: never consumed

    for (int f = 0; f < 40; f++) begin
      logic [4:0] p = (f < 32) ? 5'(f) : 5'h1F;
      if (f % 3 == 0) begin
        if (f % 8 == 5) wr(3'd1, f % 7, 32'h0000_0103);
        else wr(3'd1, f % 7, BASE + 32'(((f * 11) % 256) << 4) + ((f % 2 == 1) ? 32'd2 : 32'd0) + 32'd1);
      end
      if (f == 21) wr(3'd1, 0, BASE + SIZE + 32'h3);    // R4/R7 branch past window
      if (f % 6 == 1) wr(3'd0, (f + 2) % 7, BASE + 32'(((f * 5) % 256) << 4) + 32'hB);
      if (f == 10) wr(3'd0, 0, BASE + SIZE);            // R7 just past window
      if (f == 20) wr(3'd0, 1, 32'h9FFF_FFF0);          // R7 below window
      if (f == 30) wr(3'd0, 3, BASE + SIZE - 32'd16);   // R7 last legal slot
      doFrame(p, f == 7);                              // R10 restart ignored
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule